// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is the write side of a three-wire serial configuration port. A host drives a serial clock, a serial data line and a latch enable. Each rising serial-clock edge pushes one bit into an 18-bit frame register, most significant bit first. When the latch enable rises, the frame's 16-bit data field is copied into one of four holding registers. The two least significant frame bits, the control field, choose which one.

The four holding registers carry divider settings for two synthesizer loops. The auxiliary loop and the main loop each have a 12-bit reference count and a 16-bit feedback count. The spare upper nibble of each reference register carries extra control bits. On the main loop that nibble selects what the multifunction output shows. Each holding register raises its own update strobe for one clock cycle when it is written.

The port inputs are asynchronous to the system clock, so they pass through a synchronizer before their edges are detected. The port has no power-down input, so it keeps loading and holding values while the synthesizers it feeds are powered down.

Top module: `serial_reg_loader`

## Requirements
- R1: A frame is the last 18 serial bits. The first bit shifted in lands in frame bit 17. The data field is frame bits 17..2 and the control field is frame bits 1..0.
- R2: A transfer happens only on a rising edge of the latch enable. Holding the latch enable high gives exactly one transfer, and a falling edge gives none.
- R3: Control value 0 writes the auxiliary reference register: `aux_ref_cnt` = data bits 11..0 and `aux_ref_ctl` = data bits 15..12.
- R4: Control value 1 writes `aux_fb_cnt` = all 16 data bits.
- R5: Control value 2 writes the main reference register: `main_ref_cnt` = data bits 11..0 and `out_sel` = data bits 15..12.
- R6: Control value 3 writes `main_fb_cnt` = all 16 data bits.
- R7: `upd_strobe[k]` is high for exactly one clock cycle per transfer to destination k (bit k = control value k), in the same cycle the new value first appears. At most one strobe bit is high at a time.
- R8: Serial-clock edges that occur while the latch enable is high are ignored, so the frame register is left unchanged.
- R9: When more than 18 bits are shifted before a transfer, only the last 18 take effect.
- R10: A register that is not addressed keeps its value through any amount of shifting and through transfers to other destinations.
- R11: While reset is asserted, every output is zero.
- R12: The port inputs pass through a two-stage synchronizer. A latch-enable rise first seen at clock edge k updates the destination and strobe at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch enable, transfer on rising edge |
| aux_ref_cnt | output | 12 | Auxiliary reference divide count |
| aux_ref_ctl | output | 4 | Auxiliary reference upper control bits |
| aux_fb_cnt | output | 16 | Auxiliary feedback divide count |
| main_ref_cnt | output | 12 | Main reference divide count |
| out_sel | output | 4 | Multifunction output select |
| main_fb_cnt | output | 16 | Main feedback divide count |
| upd_strobe | output | 4 | One-cycle update strobe per destination |

## Verification
The frame register is not visible at the ports, so a wrong internal state shows up only at the next latch-enable rise. Examples are a bit shifted while the latch enable was high, a dropped bit, or a wrong bit order. The error then appears three clock edges after that rise as a wrong value in the addressed register, or as a write to the wrong destination. The bench therefore follows every ignored-shift and overlong-frame scenario with a transfer and reads the result back. A reference model compares every output and strobe on every cycle, so an extra or late strobe is caught in the cycle it occurs.

// File: rtl/slr_pkg.sv
// Package: shared sizes and destination codes for the serial register loader.
// Assumes: the frame is the data field followed by the control field, with the
// control field in the least significant bits.
package slr_pkg;
    localparam int DATA_W  = 16;
    localparam int CTL_W   = 2;
    localparam int FRAME_W = DATA_W + CTL_W;
    localparam int REF_W   = 12;
    localparam int NUM_DST = 1 << CTL_W;

    typedef enum logic [CTL_W-1:0] {
        DST_AUX_REF  = 2'd0,
        DST_AUX_FB   = 2'd1,
        DST_MAIN_REF = 2'd2,
        DST_MAIN_FB  = 2'd3
    } dst_e;
endpackage

// File: rtl/slr_sync.sv
// Module: slr_sync
// Multi-bit, multi-stage flop synchronizer for asynchronous port pins.
// Assumes: each bit is an independent slow level (the host holds every level
// for several system clocks), so per-bit skew between bits does not matter.
module slr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Purpose: pass the value one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/slr_shifter.sv
// Module: slr_shifter
// Detects rising edges of the synchronized serial clock and latch enable. It
// shifts data MSB first into the frame register and emits a one-cycle load
// request when the latch enable rises.
// Assumes: inputs are already synchronized to clk.
module slr_shifter #(
    parameter int FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdata_s,
    input  logic               latch_s,
    output logic [FRAME_W-1:0] frame,
    output logic               load_req
);
    logic sclk_d;
    logic latch_d;
    logic sclk_rise;
    logic latch_rise;

    // Purpose: hold last-cycle levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            latch_d <= 1'b0;
        end else begin
            sclk_d  <= sclk_s;
            latch_d <= latch_s;
        end
    end

    // Purpose: derive single-cycle rising-edge events.
    always_comb begin
        sclk_rise  = sclk_s & ~sclk_d;
        latch_rise = latch_s & ~latch_d;
    end

    // Purpose: shift one bit in per serial clock edge while latch enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (sclk_rise && !latch_s) begin
            frame <= {frame[FRAME_W-2:0], sdata_s};
        end
    end

    // Purpose: the load request is the latch-enable rising edge.
    always_comb begin
        load_req = latch_rise;
    end
endmodule

// File: rtl/slr_bank.sv
// Module: slr_bank
// Decodes the frame's control field and writes the data field into the
// addressed holding register, raising that register's strobe for one cycle.
// Assumes: load_req is a single-cycle pulse; the frame is stable while it is high.
module slr_bank #(
    parameter int DATA_W = 16,
    parameter int CTL_W  = 2,
    localparam int FRAME_W = DATA_W + CTL_W,
    localparam int NUM_DST = 1 << CTL_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_req,
    input  logic [FRAME_W-1:0]              frame,
    output logic [NUM_DST-1:0][DATA_W-1:0]  regs,
    output logic [NUM_DST-1:0]              strobe
);
    logic [CTL_W-1:0]   ctl_field;
    logic [DATA_W-1:0]  data_field;
    logic [NUM_DST-1:0] sel;

    // Purpose: split the frame into address and payload.
    always_comb begin
        ctl_field  = frame[CTL_W-1:0];
        data_field = frame[FRAME_W-1:CTL_W];
    end

    generate
        for (genvar k = 0; k < NUM_DST; k++) begin : g_dst
            // Purpose: one-hot write enable for destination k.
            always_comb begin
                sel[k] = load_req && (ctl_field == CTL_W'(k));
            end

            // Purpose: holding register k with its update strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[k]   <= '0;
                    strobe[k] <= 1'b0;
                end else begin
                    strobe[k] <= sel[k];
                    if (sel[k]) regs[k] <= data_field;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/serial_reg_loader.sv
// Module: serial_reg_loader (top)
// Three-wire serial write port feeding four addressed divider registers.
// Assumes: the host holds each serial level for several clk cycles. There is
// no power-down input, so loading works regardless of synthesizer state.
module serial_reg_loader
    import slr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    output logic [REF_W-1:0]  aux_ref_cnt,
    output logic [3:0]        aux_ref_ctl,
    output logic [DATA_W-1:0] aux_fb_cnt,
    output logic [REF_W-1:0]  main_ref_cnt,
    output logic [3:0]        out_sel,
    output logic [DATA_W-1:0] main_fb_cnt,
    output logic [NUM_DST-1:0] upd_strobe
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0]                  pins_s;
    logic [FRAME_W-1:0]                frame;
    logic                              load_req;
    logic [NUM_DST-1:0][DATA_W-1:0]    regs;

    slr_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_latch, ser_data, ser_clk}),
        .d_out (pins_s)
    );

    slr_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .sdata_s  (pins_s[1]),
        .latch_s  (pins_s[2]),
        .frame    (frame),
        .load_req (load_req)
    );

    slr_bank #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .frame    (frame),
        .regs     (regs),
        .strobe   (upd_strobe)
    );

    // Purpose: map holding registers onto named fields.
    always_comb begin
        aux_ref_cnt  = regs[DST_AUX_REF][REF_W-1:0];
        aux_ref_ctl  = regs[DST_AUX_REF][DATA_W-1:REF_W];
        aux_fb_cnt   = regs[DST_AUX_FB];
        main_ref_cnt = regs[DST_MAIN_REF][REF_W-1:0];
        out_sel      = regs[DST_MAIN_REF][DATA_W-1:REF_W];
        main_fb_cnt  = regs[DST_MAIN_FB];
    end
endmodule

// File: rtl/slr_checker.sv
// Module: slr_checker
// Port-level properties of serial_reg_loader, attached with bind.
module slr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] aux_ref_cnt,
    input logic [3:0]  aux_ref_ctl,
    input logic [15:0] aux_fb_cnt,
    input logic [11:0] main_ref_cnt,
    input logic [3:0]  out_sel,
    input logic [15:0] main_fb_cnt,
    input logic [3:0]  upd_strobe
);
    p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_strobe));

    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe != 4'd0) |=> (upd_strobe == 4'd0));

    p_hold_aux_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe[0] |-> $stable({aux_ref_ctl, aux_ref_cnt}));

    p_hold_aux_fb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe[1] |-> $stable(aux_fb_cnt));

    p_hold_main_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe[2] |-> $stable({out_sel, main_ref_cnt}));

    p_hold_main_fb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe[3] |-> $stable(main_fb_cnt));

    p_reset_zero_r11: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (upd_strobe == 4'd0 && aux_fb_cnt == 16'd0
                               && main_fb_cnt == 16'd0 && aux_ref_cnt == 12'd0
                               && main_ref_cnt == 12'd0 && out_sel == 4'd0
                               && aux_ref_ctl == 4'd0)));
endmodule

bind serial_reg_loader slr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .aux_ref_cnt  (aux_ref_cnt),
    .aux_ref_ctl  (aux_ref_ctl),
    .aux_fb_cnt   (aux_fb_cnt),
    .main_ref_cnt (main_ref_cnt),
    .out_sel      (out_sel),
    .main_fb_cnt  (main_fb_cnt),
    .upd_strobe   (upd_strobe)
);

// File: tb/tb_serial_reg_loader.sv
module tb_serial_reg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_latch = 1'b0;
    logic [11:0] aux_ref_cnt, main_ref_cnt;
    logic [3:0]  aux_ref_ctl, out_sel, upd_strobe;
    logic [15:0] aux_fb_cnt, main_fb_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_reg_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .aux_ref_cnt(aux_ref_cnt), .aux_ref_ctl(aux_ref_ctl),
        .aux_fb_cnt(aux_fb_cnt), .main_ref_cnt(main_ref_cnt), .out_sel(out_sel),
        .main_fb_cnt(main_fb_cnt), .upd_strobe(upd_strobe)
    );

    // ---------------- behavioural reference model ----------------
    bit [2:0] hist[$];          // {latch, data, sclk} samples, newest first
    bit [17:0] m_bits;          // last accepted serial bits
    int unsigned m_reg [4];
    bit [3:0] m_strobe;
    int strobe_seen [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b000, 3'b000, 3'b000};
            m_bits = '0;
            for (int k = 0; k < 4; k++) m_reg[k] = 0;
            m_strobe = '0;
        end else begin
            bit [2:0] cur, old;
            cur = hist[1];       // seen two edges ago through the synchronizer
            old = hist[2];
            m_strobe = '0;
            if (cur[2] && !old[2]) begin
                int dst;
                dst = int'(m_bits[1:0]);
                m_reg[dst] = int'(m_bits[17:2]);
                m_strobe[dst] = 1'b1;
            end
            if (cur[0] && !old[0] && !cur[2])
                m_bits = {m_bits[16:0], cur[1]};
            void'(hist.pop_back());
            hist.push_front({ser_latch, ser_data, ser_clk});
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison with the model (R12 timing, R7 strobes, R3-R6 fields).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R12 model aux_ref", {aux_ref_ctl, aux_ref_cnt}, m_reg[0]);
            chk("R12 model aux_fb", aux_fb_cnt, m_reg[1]);
            chk("R12 model main_ref", {out_sel, main_ref_cnt}, m_reg[2]);
            chk("R12 model main_fb", main_fb_cnt, m_reg[3]);
            chk("R7 model strobe", upd_strobe, m_strobe);
            for (int k = 0; k < 4; k++) if (upd_strobe[k]) strobe_seen[k]++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(bit b);
        ser_data = b; ser_clk = 1'b0; idle(3);
        ser_clk = 1'b1; idle(3);
        ser_clk = 1'b0; idle(1);
    endtask

    task automatic send_bits(bit [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic latch_pulse(int hi);
        ser_latch = 1'b1; idle(hi);
        ser_latch = 1'b0; idle(6);
    endtask

    task automatic write_word(bit [15:0] d, bit [1:0] c);
        send_bits({14'd0, d, c}, 18);
        latch_pulse(4);
    endtask

    task automatic clear_seen();
        for (int k = 0; k < 4; k++) strobe_seen[k] = 0;
    endtask

    initial begin
        idle(4);
        // R11: reset clears every output
        chk("R11 reset", {aux_ref_ctl, aux_ref_cnt, out_sel, main_ref_cnt}, 0);
        chk("R11 reset fb", {aux_fb_cnt, main_fb_cnt, upd_strobe}, 0);
        rst_n = 1'b1; idle(3);

        // R1/R3: control 0, MSB first
        clear_seen();
        write_word(16'hA5C3, 2'd0);
        chk("R3 aux_ref_cnt", aux_ref_cnt, 12'h5C3);
        chk("R3 aux_ref_ctl", aux_ref_ctl, 4'hA);
        chk("R7 strobe count", strobe_seen[0], 1);
        // R4
        write_word(16'h1234, 2'd1);
        chk("R4 aux_fb_cnt", aux_fb_cnt, 16'h1234);
        // R5
        write_word(16'hF0AB, 2'd2);
        chk("R5 main_ref_cnt", main_ref_cnt, 12'h0AB);
        chk("R5 out_sel", out_sel, 4'hF);
        // R6
        write_word(16'hBEEF, 2'd3);
        chk("R6 main_fb_cnt", main_fb_cnt, 16'hBEEF);
        // R10: earlier registers untouched
        chk("R10 aux_ref kept", {aux_ref_ctl, aux_ref_cnt}, 16'hA5C3);
        chk("R10 aux_fb kept", aux_fb_cnt, 16'h1234);

        // R2: long latch high gives one transfer
        clear_seen();
        send_bits({14'd0, 16'h0F0F, 2'd1}, 18);
        latch_pulse(40);
        chk("R2 one transfer", strobe_seen[1], 1);
        chk("R2 value", aux_fb_cnt, 16'h0F0F);

        // R8: bits clocked during latch high are ignored
        send_bits({14'd0, 16'h7E11, 2'd3}, 18);
        ser_latch = 1'b1; idle(4);
        send_bits({14'd0, 16'h0001, 2'd0}, 18);
        ser_latch = 1'b0; idle(6);
        clear_seen();
        latch_pulse(4);
        chk("R8 frame unchanged", main_fb_cnt, 16'h7E11);
        chk("R8 no aux_ref write", strobe_seen[0], 0);

        // R9: overlong frame keeps last 18 bits
        send_bits(32'h5, 4);
        send_bits({14'd0, 16'hC0DE, 2'd2}, 18);
        latch_pulse(4);
        chk("R9 main_ref_cnt", main_ref_cnt, 12'h0DE);
        chk("R9 out_sel", out_sel, 4'hC);

        // R12: update lands on third clock edge after the pin rises
        send_bits({14'd0, 16'h4321, 2'd1}, 18);
        ser_latch = 1'b1;
        idle(2);
        chk("R12 not yet", aux_fb_cnt, 16'h0F0F);
        idle(1);
        chk("R12 updated", aux_fb_cnt, 16'h4321);
        chk("R12 strobe", upd_strobe, 4'b0010);
        ser_latch = 1'b0; idle(6);

        // R10: shifting alone changes nothing
        send_bits(32'hFFFF_FFFF, 20);
        idle(4);
        chk("R10 shift only", main_fb_cnt, 16'h7E11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule